// File: doc/BRIEF.md
# Gated Toggle Photon-Event Row Combiner

This block models one row of photon receiver elements. Each element has a single-cycle detection pulse input and a stored enable bit. When an element is enabled, each pulse flips a private toggle register. When it is disabled, the register holds its value. The toggle states of all elements are merged by an XOR tree into one row signal. Each photon event on an enabled element therefore shows up as one transition on the row output. Rising and falling transitions both mean "one event". The output is not a pulse count and not an OR of the inputs.

The enable bits are loaded through a masked write port. One vector selects which elements are written and a second vector gives their new values. Disabling elements shrinks the active area of the row. A downstream counter turns transitions into counts. That counter, and the analog detector, are outside this block.

A parameter chooses between two tree variants. The purely combinational tree has the shortest latency. The fully registered tree has one XOR gate per level between registers, for high event rates.

Top module: `photon_toggle_row`

## Requirements
- R1: After reset every toggle register is 0, the row output is 0, and every element is enabled.
- R2: A pulse on one enabled element inverts the row output exactly LAT sampled cycles after the pulse is sampled. LAT is 1 for the combinational tree and 1 + ceil(log2(N_ELEM)) for the registered tree. Repeated pulses give alternating rising and falling transitions.
- R3: A pulse on a disabled element leaves the row output unchanged.
- R4: A write with `cfg_wr` high updates only the enable bits whose `cfg_sel` bit is 1, each to the matching `cfg_val` bit (1 = enabled). All other enable bits keep their value. With `cfg_wr` low the mask does not change.
- R5: Changing enable bits alone, with no pulse on an enabled element, never causes a transition on the row output.
- R6: When several elements pulse in the same cycle, the row output inverts if and only if an odd number of those pulses fall on enabled elements.
- R7: A pulse sampled in the same cycle as a write to its element's enable bit is gated by the enable value held before that write.
- R8: Over a stream with at most one pulse per cycle, and a minimum spacing per element, the number of row-output transitions equals the number of pulses applied to enabled elements.
- R9: Every element position, from index 0 to index N_ELEM-1, contributes to the row output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_pulse | input | N_ELEM | Single-cycle detection pulse per element |
| cfg_wr | input | 1 | Enable-mask write strobe |
| cfg_sel | input | N_ELEM | Per-element write select |
| cfg_val | input | N_ELEM | New enable value for selected elements |
| row_evt | output | 1 | Double-edge event signal: each transition is one event |

## Verification
The bench drives the following patterns:
- A walking single pulse across every position. This separates a missing or swapped leaf and shows both edge polarities.
- Pulses on elements that have been disabled by full and by partial masked writes. These show whether gating and write selection are honoured.
- Coincident groups of two and three pulses, with enabled and disabled elements mixed. These tell parity merging apart from OR or counting behaviour.
- Writes landing in the same cycle as pulses on the same element. These tell old-enable from new-enable gating.
- A long pseudo-random stream with dead-time spacing and interleaved mask changes. This compares the total transition count against the number of enabled pulses.

// File: rtl/ptr_pkg.sv
package ptr_pkg;

   // Selects the structure of the row reduction network.
   typedef enum logic {
      TREE_COMB  = 1'b0,
      TREE_PIPED = 1'b1
   } tree_mode_e;

   // Sampled-cycle latency from a pulse input to the row output.
   function automatic int row_latency(input int n_elem, input tree_mode_e mode);
      return 1 + ((mode == TREE_PIPED) ? $clog2(n_elem) : 0);
   endfunction

endpackage

// File: rtl/ptr_enable_mask.sv
module ptr_enable_mask #(
   parameter int N_ELEM = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [N_ELEM-1:0] sel_i,
   input  logic [N_ELEM-1:0] val_i,
   output logic [N_ELEM-1:0] mask_o
);

   logic [N_ELEM-1:0] mask_q;

   // Reset state: every element enabled.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
      end else if (wr_i) begin
         mask_q <= (mask_q & ~sel_i) | (val_i & sel_i);
      end
   end

   assign mask_o = mask_q;

   AST_MASK_UNSELECTED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> ((mask_q & ~$past(sel_i)) == ($past(mask_q) & ~$past(sel_i)))); // R4
   AST_MASK_SELECTED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> ((mask_q & $past(sel_i)) == ($past(val_i) & $past(sel_i)))); // R4
   AST_MASK_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(mask_q)); // R4

endmodule

// File: rtl/ptr_toggle_cell.sv
module ptr_toggle_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse_i,
   input  logic en_i,
   output logic tog_o
);

   logic tog_q;

   // Gating sits at the toggle input, so a change of enable never moves tog_q.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_q <= 1'b0;
      end else if (pulse_i && en_i) begin
         tog_q <= ~tog_q;
      end
   end

   assign tog_o = tog_q;

   AST_CELL_FLIPS_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_i && en_i) |=> (tog_q != $past(tog_q))); // R2
   AST_CELL_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> $stable(tog_q)); // R3

endmodule

// File: rtl/ptr_xor_tree.sv
module ptr_xor_tree
   import ptr_pkg::*;
#(
   parameter int         N_LEAF = 32,
   parameter tree_mode_e MODE   = TREE_PIPED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_LEAF-1:0] leaf_i,
   output logic              root_o
);

   localparam int LVL = $clog2(N_LEAF);
   localparam int W2  = 1 << LVL;

   if (N_LEAF < 2) begin : g_bad_width
      $fatal(1, "ptr_xor_tree needs at least two leaves");
   end

   // Leaves padded with zeros up to a power of two; zero is neutral for XOR.
   logic [W2-1:0] leaf_pad;
   assign leaf_pad = W2'(leaf_i);

   // Heap layout: node k has children 2k and 2k+1, leaves at W2..2*W2-1.
   if (MODE == TREE_PIPED) begin : g_piped
      logic [W2-1:1]   node_q;
      logic [2*W2-1:1] heap;

      assign heap = {leaf_pad, node_q};

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            node_q <= '0;
         end else begin
            for (int k = 1; k < W2; k++) begin
               node_q[k] <= heap[2*k] ^ heap[2*k+1];
            end
         end
      end

      assign root_o = node_q[1];
   end else begin : g_comb
      logic root_c;

      always_comb begin
         logic [2*W2-1:1] v;
         v = {leaf_pad, {(W2-1){1'b0}}};
         for (int k = W2-1; k >= 1; k--) begin
            v[k] = v[2*k] ^ v[2*k+1];
         end
         root_c = v[1];
      end

      assign root_o = root_c;
   end

endmodule

// File: rtl/photon_toggle_row.sv
module photon_toggle_row
   import ptr_pkg::*;
#(
   parameter int         N_ELEM    = 32,
   parameter tree_mode_e TREE_MODE = TREE_PIPED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_ELEM-1:0] det_pulse,
   input  logic              cfg_wr,
   input  logic [N_ELEM-1:0] cfg_sel,
   input  logic [N_ELEM-1:0] cfg_val,
   output logic              row_evt
);

   localparam int LAT = row_latency(N_ELEM, TREE_MODE);
   localparam int QW  = $clog2(LAT + 2);

   if (N_ELEM < 2) begin : g_bad_elem
      $fatal(1, "photon_toggle_row needs at least two elements");
   end

   logic [N_ELEM-1:0] en_mask;
   logic [N_ELEM-1:0] tog;

   ptr_enable_mask #(
      .N_ELEM (N_ELEM)
   ) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (cfg_wr),
      .sel_i  (cfg_sel),
      .val_i  (cfg_val),
      .mask_o (en_mask)
   );

   for (genvar i = 0; i < N_ELEM; i++) begin : g_cell
      ptr_toggle_cell u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .pulse_i (det_pulse[i]),
         .en_i    (en_mask[i]),
         .tog_o   (tog[i])
      );
   end

   ptr_xor_tree #(
      .N_LEAF (N_ELEM),
      .MODE   (TREE_MODE)
   ) u_tree (
      .clk    (clk),
      .rst_n  (rst_n),
      .leaf_i (tog),
      .root_o (row_evt)
   );

   // Checker state: consecutive sampled cycles without an enabled pulse.
   logic [QW-1:0] quiet_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quiet_cnt <= '0;
      end else if ((det_pulse & en_mask) != '0) begin
         quiet_cnt <= '0;
      end else if (quiet_cnt < QW'(LAT)) begin
         quiet_cnt <= quiet_cnt + 1'b1;
      end
   end

   AST_NO_SPURIOUS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet_cnt >= QW'(LAT)) |-> $stable(row_evt)); // R5

endmodule

// File: tb/photon_toggle_row_bench.sv
`timescale 1ns/1ps
module photon_toggle_row_bench;
   import ptr_pkg::*;

   localparam int         N    = 32;
   localparam tree_mode_e MODE = TREE_PIPED;
   localparam int         LAT  = 1 + $clog2(N);   // cell register plus one register per tree level
   localparam int         DEAD = 3;               // minimum per-element pulse spacing in cycles

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] det_pulse = '0;
   logic         cfg_wr = 1'b0;
   logic [N-1:0] cfg_sel = '0;
   logic [N-1:0] cfg_val = '0;
   logic         row_evt;

   photon_toggle_row #(.N_ELEM(N), .TREE_MODE(MODE)) u_photon_toggle_row (
      .clk(clk), .rst_n(rst_n), .det_pulse(det_pulse), .cfg_wr(cfg_wr),
      .cfg_sel(cfg_sel), .cfg_val(cfg_val), .row_evt(row_evt)
   );

   always #2.5 clk = ~clk;

   int     compared = 0;
   int     mismatched = 0;
   longint cyc = 0;
   bit     run = 0;
   bit     done = 0;

   logic [N-1:0] model_mask = '1;
   logic         exp_lvl = 1'b0;
   int           edges_seen = 0;
   logic         prev_evt = 1'b0;

   longint q_cyc[$];
   logic   q_lvl[$];
   string  q_req[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   // Driver: one call per cycle, pushes the expected row level into the scoreboard.
   task automatic step(input logic [N-1:0] det, input string req,
                       input logic wr = 1'b0, input logic [N-1:0] sel = '0,
                       input logic [N-1:0] val = '0);
      @(posedge clk);
      #1;
      det_pulse = det;
      cfg_wr    = wr;
      cfg_sel   = sel;
      cfg_val   = val;
      if (^(det & model_mask)) exp_lvl = ~exp_lvl;          // R6 parity, R7 old mask
      if (wr) model_mask = (model_mask & ~sel) | (val & sel); // R4
      q_cyc.push_back(cyc + LAT);
      q_lvl.push_back(exp_lvl);
      q_req.push_back(req);
   endtask

   task automatic idle(input int n, input string req);
      for (int i = 0; i < n; i++) step('0, req);
   endtask

   // Monitor: compares the row output with the scoreboard, counts transitions.
   always @(negedge clk) begin
      if (run) begin
         if (row_evt !== prev_evt) edges_seen++;
         prev_evt = row_evt;
         while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
            check(row_evt === q_lvl[0], q_req[0], longint'(row_evt), longint'(q_lvl[0]));
            void'(q_cyc.pop_front());
            void'(q_lvl.pop_front());
            void'(q_req.pop_front());
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   function automatic logic [31:0] xs32(input logic [31:0] s);
      logic [31:0] x;
      x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   initial begin
      logic [31:0] rnd;
      longint      last_hit [N];
      int          e0;
      int          stream_pulses;

      // R1: reset state
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(row_evt === 1'b0, "R1 reset output", longint'(row_evt), 0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      run = 1;
      @(negedge clk);
      check(row_evt === 1'b0, "R1 after release", longint'(row_evt), 0);

      // R2/R9 with R1 all-enabled mask: walk a pulse over every position
      for (int i = 0; i < N; i++) begin
         step(N'(1) << i, "R9 walk");
         idle(1, "R2 walk");
      end
      step(N'(1) << (N-1), "R9 top index");
      idle(LAT + 2, "R2 drain");

      // R5: disable the odd elements, no edge from the write itself
      step('0, "R5 full write", 1'b1, '1, {(N/2){2'b01}});
      idle(LAT + 2, "R5 after write");
      step(N'(1) << 1, "R3 disabled pulse");
      idle(LAT, "R3 hold");
      step(N'(1) << 0, "R4 enabled kept");
      idle(LAT, "R2 after enabled");

      // R4: partial write over elements 4..7
      step('0, "R5 partial write", 1'b1, N'(32'h0000_00F0), N'(32'h0000_00A0));
      idle(LAT, "R5 after partial");
      step(N'(1) << 4, "R4 newly disabled");
      idle(2, "R4");
      step(N'(1) << 5, "R4 newly enabled");
      idle(2, "R4");
      step(N'(1) << 8, "R4 unselected kept on");
      idle(2, "R4");
      step(N'(1) << 9, "R4 unselected kept off");
      idle(LAT, "R4 drain");

      // R6: coincident pulses
      step(N'(32'h0000_0005), "R6 two enabled");
      idle(2, "R6");
      step(N'(32'h0000_0105), "R6 three enabled");
      idle(2, "R6");
      step(N'(32'h0000_0007), "R6 two enabled one disabled");
      idle(2, "R6");
      step('1, "R6 all elements");
      idle(LAT, "R6 drain");

      // R7: write and pulse on the same element in the same cycle
      step(N'(1) << 5, "R7 disable same cycle", 1'b1, N'(1) << 5, '0);
      step(N'(1) << 5, "R7 now disabled");
      idle(2, "R7");
      step(N'(1) << 9, "R7 enable same cycle", 1'b1, N'(1) << 9, N'(1) << 9);
      step(N'(1) << 9, "R7 now enabled");
      idle(LAT + 2, "R7 drain");

      // R8: spaced pseudo-random stream with mask changes
      step('0, "R5 restore", 1'b1, '1, '1);
      idle(LAT + 2, "R8 settle");
      e0 = edges_seen;
      stream_pulses = 0;
      rnd = 32'h1234_5678;
      for (int i = 0; i < N; i++) last_hit[i] = -100;
      for (int t = 0; t < 3000; t++) begin
         int idx;
         logic [N-1:0] det;
         logic [N-1:0] sel;
         logic [N-1:0] val;
         logic wr;
         rnd = xs32(rnd);
         idx = int'(rnd[12:8]) % N;
         det = '0;
         if (rnd[0] && (longint'(t) - last_hit[idx] >= DEAD)) begin
            det[idx] = 1'b1;
            last_hit[idx] = t;
            if (model_mask[idx]) stream_pulses++;
         end
         wr  = (rnd[20:15] == 6'd0);
         sel = N'(xs32(rnd));
         val = N'(xs32(~rnd));
         step(det, "R8 stream", wr, sel, val);
      end
      idle(LAT + 3, "R8 drain");
      @(negedge clk);
      check(edges_seen - e0 == stream_pulses, "R8 edge count",
            longint'(edges_seen - e0), longint'(stream_pulses));

      finish_run();
   end

endmodule